// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block folds a wide bundle of level-sensitive interrupt lines into one output per combiner, where each combiner owns eight adjacent lines. A combiner output is high while at least one of its lines is high and is enabled. Four combiners share one bank of 32-bit registers. Each combiner uses one byte lane of its bank, so the bank covers 32 lines.

Software reaches the block through a single-cycle 32-bit register port. Enable bits are never written directly. One register sets the bits written as one and another clears them, so two agents can change disjoint lines of a bank without a read-modify-write. A third register per bank returns the masked, live state of the bank's lines. The number of combiners is a parameter. The number of banks is derived from it, and each bank sits at its own 16-byte window.

The block has no state machine. Its sequencing is one register stage on the enables, one on each combiner output and one on the read data.

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `comb_out` bit is 0 and `reg_rdata` is 0, whatever `irq_in` does.
- R2: A write to bank offset 0x0 sets each enable bit whose `reg_wdata` bit is 1 and leaves the others unchanged; the new mask is in effect from the following cycle.
- R3: A write to bank offset 0x4 clears each enable bit whose `reg_wdata` bit is 1 and leaves the others unchanged.
- R4: A read of offset 0x0 or 0x4 of a bank returns that bank's 32-bit enable mask. `reg_rdata` carries the value in the cycle after `reg_rd` and holds it until the next read.
- R5: A read of offset 0xC returns the bank's 32 inputs ANDed bitwise with its enable mask. Global input c*8+k (combiner c, line k) is bit ((c mod 4)*8+k) of bank c/4.
- R6: `comb_out[c]` is the OR of combiner c's enabled, asserted lines, registered once. It follows a level change on `irq_in` one clock edge later and stays high while such a line stays high.
- R7: Bank g is at byte address 0x10*g. A write to one bank leaves the enables of every other bank unchanged.
- R8: Offset 0x8, any offset whose low nibble is not 0x0, 0x4 or 0xC, and any bank index at or above the bank count are unmapped. Reads there return 0 and writes there change nothing. A write to offset 0xC changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_COMB*8 | Level interrupt lines, combiner c line k at index c*8+k |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| comb_out | output | NUM_COMB | One combined level output per combiner |

## Verification
A write takes effect at the clock edge that samples it. The new mask shows on a read issued the following cycle and on `comb_out` one edge after that. A change on `irq_in` reaches `comb_out` one edge after it is applied, and read data appears one edge after `reg_rd`. The bench drives every input just after a falling edge and samples each result at the next falling edge after the edge that is due to produce it. It also samples `comb_out` immediately after an input change, which shows that no combinational path bypasses the output register.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
    localparam int LINES_PER_COMB = 8;
    localparam int COMB_PER_BANK  = 4;
    localparam int BANK_BITS      = LINES_PER_COMB * COMB_PER_BANK;

    localparam logic [3:0] OFS_EN_SET = 4'h0;
    localparam logic [3:0] OFS_EN_CLR = 4'h4;
    localparam logic [3:0] OFS_MASKED = 4'hC;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_ENABLE = 2'd1,
        RK_MASKED = 2'd2
    } rd_kind_t;
endpackage

// File: rtl/comb_addr_decode.sv
module comb_addr_decode
    import irq_combiner_pkg::*;
#(
    parameter int NUM_BANK = 5,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_BANK-1:0] set_sel,
    output logic [NUM_BANK-1:0] clr_sel,
    output logic [NUM_BANK-1:0] rd_sel,
    output rd_kind_t          rd_kind
);
    localparam int BF_W = ADDR_W - 4;

    logic [BF_W-1:0] bank_f;
    logic [3:0]      ofs_f;

    assign bank_f = addr[ADDR_W-1:4];
    assign ofs_f  = addr[3:0];

    always_comb begin
        set_sel = '0;
        clr_sel = '0;
        rd_sel  = '0;
        rd_kind = RK_NONE;
        for (int g = 0; g < NUM_BANK; g++) begin
            if (bank_f == BF_W'(g)) begin
                set_sel[g] = wr && (ofs_f == OFS_EN_SET);
                clr_sel[g] = wr && (ofs_f == OFS_EN_CLR);
                if (rd) begin
                    unique case (ofs_f)
                        OFS_EN_SET, OFS_EN_CLR: begin
                            rd_sel[g] = 1'b1;
                            rd_kind   = RK_ENABLE;
                        end
                        OFS_MASKED: begin
                            rd_sel[g] = 1'b1;
                            rd_kind   = RK_MASKED;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R8: at most one bank is picked for any access
    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_sel | clr_sel | rd_sel));

    // R8: set and clear are never decoded together
    assert_set_clr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((|set_sel) && (|clr_sel)));
endmodule

// File: rtl/comb_bank.sv
module comb_bank
    import irq_combiner_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_BITS-1:0] lines,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [BANK_BITS-1:0] wdata,
    output logic [BANK_BITS-1:0] en_q,
    output logic [BANK_BITS-1:0] masked,
    output logic [LANES-1:0]     lane_out
);
    localparam int VALID_BITS = LANES * LINES_PER_COMB;
    localparam logic [BANK_BITS-1:0] VMASK =
        (VALID_BITS >= BANK_BITS) ? {BANK_BITS{1'b1}}
                                  : BANK_BITS'((64'd1 << VALID_BITS) - 64'd1);

    logic [BANK_BITS-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (set_we)
            en_d = en_q | wdata;
        else if (clr_we)
            en_d = en_q & ~wdata;
        en_d = en_d & VMASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else
            en_q <= en_d;
    end

    assign masked = lines & en_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_out[l] <= 1'b0;
            else
                lane_out[l] <= |masked[l*LINES_PER_COMB +: LINES_PER_COMB];
        end

        // R6: output follows the masked lines one edge later
        assert_lane_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lane_out[l] == $past(|(lines[l*LINES_PER_COMB +: LINES_PER_COMB]
                                   & en_q[l*LINES_PER_COMB +: LINES_PER_COMB])));
    end

    // R2: set writes only add the written ones
    assert_set_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> en_q == (($past(en_q) | $past(wdata)) & VMASK));

    // R3: clear writes only remove the written ones
    assert_clr_removes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> en_q == ($past(en_q) & ~$past(wdata)));

    // R7: without a write to this bank its enables hold
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(en_q));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_combiner_pkg::*;
#(
    parameter int NUM_COMB = 20,
    parameter int ADDR_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_COMB*LINES_PER_COMB-1:0] irq_in,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_wr,
    input  logic [31:0]                    reg_wdata,
    input  logic                           reg_rd,
    output logic [31:0]                    reg_rdata,
    output logic [NUM_COMB-1:0]            comb_out
);
    localparam int NUM_BANK = (NUM_COMB + COMB_PER_BANK - 1) / COMB_PER_BANK;
    localparam int NUM_IN   = NUM_COMB * LINES_PER_COMB;
    localparam int PAD_W    = NUM_BANK * BANK_BITS;

    logic [PAD_W-1:0]    irq_pad;
    logic [NUM_BANK-1:0] set_sel, clr_sel, rd_sel;
    rd_kind_t            rd_kind;
    logic [BANK_BITS-1:0] en_all [NUM_BANK];
    logic [BANK_BITS-1:0] mk_all [NUM_BANK];
    logic [31:0]          rd_mux;

    assign irq_pad = PAD_W'(irq_in);

    comb_addr_decode #(.NUM_BANK(NUM_BANK), .ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .set_sel (set_sel),
        .clr_sel (clr_sel),
        .rd_sel  (rd_sel),
        .rd_kind (rd_kind)
    );

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        localparam int LN = (NUM_COMB - g*COMB_PER_BANK >= COMB_PER_BANK)
                            ? COMB_PER_BANK : (NUM_COMB - g*COMB_PER_BANK);
        logic [LN-1:0] lo;

        comb_bank #(.LANES(LN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lines    (irq_pad[g*BANK_BITS +: BANK_BITS]),
            .set_we   (set_sel[g]),
            .clr_we   (clr_sel[g]),
            .wdata    (reg_wdata),
            .en_q     (en_all[g]),
            .masked   (mk_all[g]),
            .lane_out (lo)
        );

        assign comb_out[g*COMB_PER_BANK +: LN] = lo;
    end

    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NUM_BANK; g++) begin
            if (rd_sel[g]) begin
                unique case (rd_kind)
                    RK_ENABLE: rd_mux = rd_mux | en_all[g];
                    RK_MASKED: rd_mux = rd_mux | mk_all[g];
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    // R8: unmapped reads come back as zero
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && rd_kind == RK_NONE) |=> reg_rdata == 32'h0);

    // R4: read data holds between reads
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R1: nothing enabled right after reset, so every output is low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> comb_out == '0);
endmodule

// File: tb/irq_combiner_test.sv
`timescale 1ns/1ps
module irq_combiner_test;
    localparam int NC = 20;
    localparam int NI = NC * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_in = '0;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] comb_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_combiner #(.NUM_COMB(NC), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .comb_out(comb_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // op: 1 = write, 2 = read; fields {op, addr, data, expected}
    localparam logic [73:0] VEC [18] = '{
        {2'd1, 8'h00, 32'h0000_00FF, 32'h0},          // R2 set bank 0
        {2'd2, 8'h00, 32'h0,         32'h0000_00FF},  // R4
        {2'd2, 8'h0C, 32'h0,         32'h0000_00F0},  // R5
        {2'd1, 8'h10, 32'h1234_5678, 32'h0},          // R7 bank 1 at 0x10
        {2'd2, 8'h10, 32'h0,         32'h1234_5678},  // R7
        {2'd2, 8'h00, 32'h0,         32'h0000_00FF},  // R7 bank 0 untouched
        {2'd1, 8'h14, 32'h0000_FF00, 32'h0},          // R3 clear
        {2'd2, 8'h14, 32'h0,         32'h1234_0078},  // R3
        {2'd1, 8'h00, 32'h0,         32'h0},          // R2 zeros
        {2'd2, 8'h04, 32'h0,         32'h0000_00FF},  // R2
        {2'd2, 8'h1C, 32'h0,         32'h1200_0070},  // R5
        {2'd1, 8'h0C, 32'hFFFF_FFFF, 32'h0},          // R8 write to 0xC
        {2'd2, 8'h00, 32'h0,         32'h0000_00FF},  // R8
        {2'd2, 8'h08, 32'h0,         32'h0},          // R8 offset 0x8
        {2'd2, 8'h50, 32'h0,         32'h0},          // R8 bank 5
        {2'd1, 8'h40, 32'hFFFF_FFFF, 32'h0},          // R2 bank 4
        {2'd2, 8'h4C, 32'h0,         32'hFF00_F0F0},  // R5
        {2'd2, 8'h02, 32'h0,         32'h0}           // R8 unaligned
    };

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        irq_in = '1;
        @(negedge clk);
        chk("R1 comb_out", 32'(comb_out), 32'h0);
        chk("R1 rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 comb_out after release", 32'(comb_out), 32'h0);
        rd_reg(8'h40, d);
        chk("R1 bank 4 enables", d, 32'h0);

        irq_in = {5{32'hFF00_F0F0}};
        for (int i = 0; i < 18; i++) begin
            if (VEC[i][73:72] == 2'd1) begin
                wr_reg(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd_reg(VEC[i][71:64], d);
                chk($sformatf("R4/R5/R7/R8 vector %0d", i), d, VEC[i][31:0]);
            end
        end

        @(negedge clk);
        chk("R6 combined outputs", 32'(comb_out), 32'h000B_0091);

        // R6: drop combiner 7 lines, output falls one edge later only
        irq_in[63:56] = 8'h00;
        #1;
        chk("R6 registered, no early change", 32'(comb_out[7]), 32'h1);
        @(negedge clk);
        chk("R6 falls after one edge", 32'(comb_out[7]), 32'h0);
        irq_in[63:56] = 8'h10;
        @(negedge clk);
        chk("R6 rises after one edge", 32'(comb_out[7]), 32'h1);
        repeat (3) @(negedge clk);
        chk("R6 level held", 32'(comb_out[7]), 32'h1);

        // R3: clear combiner 19 enables, output drops
        wr_reg(8'h44, 32'hFF00_0000);
        chk("R3 output not yet updated", 32'(comb_out[19]), 32'h1);
        @(negedge clk);
        chk("R3 combiner 19 masked", 32'(comb_out[19]), 32'h0);
        chk("R3 combiner 16 kept", 32'(comb_out[16]), 32'h1);

        // R1: reset mid-run clears enables
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", 32'(comb_out), 32'h0);
        rd_reg(8'h10, d);
        chk("R1 bank 1 enables after reset", d, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule